// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Three Guarded Accumulators

This block is the multiply-accumulate stage of a small fixed-point signal processor. It holds three 22-bit accumulators. Each one carries a 16-bit fraction (bit 15 is the sign of a 1.15 value, so +1.0 is `0x008000`) and six guard bits above it. A 4-bit opcode picks the operation. Three 2-bit selectors name the destination accumulator (x) and the two source accumulators (y, z). A selector that the opcode does not use is ignored.

The datapath has one signed 8×8 multiplier for the fractional products. Constant scaling by 4.0 and by 1.5 is done with shifts and an adder, not with the multiplier. Rounding is followed by saturation to the 1.7 output range. Three slice reads return the low, middle or guard byte of an accumulator on an 8-bit register-file write port, and the guard slice is sign-extended to 8 bits.

Accumulator writes take effect at the next rising clock edge. The slice reads and the saturation indication are combinational in the current cycle.

Top module: `frac_mac_unit`

## Requirements
- R1: After an active-low reset, all three accumulators read back as zero.
- R2: Opcode 1 writes the signed product A×B into ACCx, shifted left by one and sign-extended to 22 bits. For example, `0x80`×`0x80` gives `0x008000`.
- R3: Opcode 2 writes A×B (aligned as in R2) plus ACCy into ACCx, wrapping modulo 2^22.
- R4: Opcode 3 writes ACCy shifted left by two bits into ACCx, wrapping modulo 2^22.
- R5: Opcode 4 writes ACCy plus ACCy arithmetically shifted right by one into ACCx, wrapping modulo 2^22.
- R6: Opcode 5 loads the 8-bit register value into bits [15:8] of ACCx. Bits [7:0] are cleared and bits [21:16] are copies of the register's bit 7.
- R7: Opcode 6 adds `0x80` to ACCy, clears bits [7:0], and writes the result into ACCx clamped to the range `-0x8000`..`+0x7F00`. While the opcode is present, `sat_o` is high exactly when the clamp changed the value.
- R8: Opcode 7 writes ACCy+ACCz and opcode 8 writes ACCy−ACCz into ACCx, both wrapping modulo 2^22.
- R9: Opcodes 9, 10 and 11 drive ACCy bits [7:0], [15:8], and [21:16] sign-extended to 8 bits onto `rf_data_o` in the same cycle. `rf_we_o` is high for these three opcodes and low for all others.
- R10: A destination selector of 3 writes nothing. A source selector of 3 reads as zero. Opcodes 0, 9–15 leave all accumulators unchanged.
- R11: At most one accumulator is written per cycle, and the written value is visible from the clock edge that ends the issuing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| sel_x_i | input | 2 | Destination accumulator select |
| sel_y_i | input | 2 | First source accumulator select |
| sel_z_i | input | 2 | Second source accumulator select |
| a_i | input | 8 | Multiplier operand A, 1.7 fraction |
| b_i | input | 8 | Multiplier operand B, 1.7 fraction |
| reg_i | input | 8 | Register value for the load operation |
| rf_data_o | output | 8 | Register-file write data from the slice reads |
| rf_we_o | output | 1 | Register-file write strobe for the slice reads |
| sat_o | output | 1 | Clamp occurred in round-and-saturate |

## Verification
On every cycle, the assertions check the following:
- At most one accumulator write strobe is high.
- Accumulators hold still for idle opcodes, read opcodes and a destination of 3.
- A load places the register byte and its sign correctly.
- A round-and-saturate result always has a zero low byte and lies inside the clamp range.
- The guard slice read is sign-extended.

The arithmetic values of products, scaling, wrap-around, and the exact rounding boundary (`0x7F80` clamping down to `0x7F00`) can only be shown by the directed scenarios. Those scenarios compare each result with a bench model written with integer arithmetic.

// File: rtl/frac_mac_pkg.sv
`timescale 1ns/1ps
package frac_mac_pkg;
  parameter int DATA_W  = 8;
  parameter int GUARD_W = 6;
  parameter int FRAC_W  = 2 * DATA_W;
  parameter int ACC_W   = FRAC_W + GUARD_W;
  parameter int PROD_W  = 2 * DATA_W;
  parameter int NACC    = 3;
  parameter int SEL_W   = 2;
  parameter int OP_W    = 4;
  parameter int LOW_W   = FRAC_W - DATA_W;

  // largest positive 1.7 value and -1.0, both in accumulator scale
  parameter logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((1 << (FRAC_W-1)) - (1 << LOW_W));
  parameter logic signed [ACC_W:0] SAT_LO = -(ACC_W+1)'(1 << (FRAC_W-1));

  typedef logic [ACC_W-1:0] acc_t;

  typedef enum logic [OP_W-1:0] {
    MOP_IDLE   = 4'd0,
    MOP_MUL    = 4'd1,
    MOP_MAC    = 4'd2,
    MOP_X4     = 4'd3,
    MOP_X1P5   = 4'd4,
    MOP_LOAD   = 4'd5,
    MOP_RNDSAT = 4'd6,
    MOP_ADD    = 4'd7,
    MOP_SUB    = 4'd8,
    MOP_RD_LO  = 4'd9,
    MOP_RD_MID = 4'd10,
    MOP_RD_HI  = 4'd11
  } mac_op_e;

  typedef struct packed {
    acc_t value;
    logic clamped;
  } rnd_res_t;

  function automatic acc_t f_align_prod(input logic [PROD_W-1:0] p);
    acc_t e;
    e = {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    return e << 1;
  endfunction

  function automatic acc_t f_times4(input acc_t v);
    return v << 2;
  endfunction

  function automatic acc_t f_times1p5(input acc_t v);
    return v + {v[ACC_W-1], v[ACC_W-1:1]};
  endfunction

  function automatic acc_t f_load(input logic [DATA_W-1:0] r);
    return {{GUARD_W{r[DATA_W-1]}}, r, {LOW_W{1'b0}}};
  endfunction

  function automatic rnd_res_t f_round_sat(input acc_t v);
    logic signed [ACC_W:0] t;
    rnd_res_t res;
    t = $signed({v[ACC_W-1], v}) + (ACC_W+1)'(1 << (LOW_W-1));
    t[LOW_W-1:0] = '0;
    res.clamped = 1'b0;
    if (t > SAT_HI) begin
      t = SAT_HI;
      res.clamped = 1'b1;
    end else if (t < SAT_LO) begin
      t = SAT_LO;
      res.clamped = 1'b1;
    end
    res.value = t[ACC_W-1:0];
    return res;
  endfunction
endpackage

// File: rtl/mac_multiplier.sv
`timescale 1ns/1ps
module mac_multiplier
  import frac_mac_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output acc_t              prod_o
);
  logic signed [PROD_W-1:0] prod_raw;

  assign prod_raw = $signed(a_i) * $signed(b_i);
  assign prod_o   = f_align_prod(prod_raw);
endmodule

// File: rtl/mac_acc_bank.sv
`timescale 1ns/1ps
module mac_acc_bank
  import frac_mac_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NACC-1:0]            we_i,
  input  acc_t                       wdata_i,
  input  logic [SEL_W-1:0]           sel_y_i,
  input  logic [SEL_W-1:0]           sel_z_i,
  output logic [NACC-1:0][ACC_W-1:0] acc_q_o,
  output acc_t                       acc_y_o,
  output acc_t                       acc_z_o
);
  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q_o[g] <= '0;
      else if (we_i[g])  acc_q_o[g] <= wdata_i;
    end
  end

  // out-of-range selectors read as zero
  always_comb begin
    acc_y_o = '0;
    acc_z_o = '0;
    for (int i = 0; i < NACC; i++) begin
      if (sel_y_i == SEL_W'(i)) acc_y_o = acc_q_o[i];
      if (sel_z_i == SEL_W'(i)) acc_z_o = acc_q_o[i];
    end
  end
endmodule

// File: rtl/mac_alu.sv
`timescale 1ns/1ps
module mac_alu
  import frac_mac_pkg::*;
(
  input  mac_op_e           op_i,
  input  acc_t              acc_y_i,
  input  acc_t              acc_z_i,
  input  acc_t              prod_i,
  input  logic [DATA_W-1:0] reg_i,
  output acc_t              wdata_o,
  output logic              wr_en_o,
  output logic              clamp_o
);
  rnd_res_t rnd;

  assign rnd = f_round_sat(acc_y_i);

  always_comb begin
    wdata_o = '0;
    wr_en_o = 1'b1;
    clamp_o = 1'b0;
    case (op_i)
      MOP_MUL:    wdata_o = prod_i;
      MOP_MAC:    wdata_o = prod_i + acc_y_i;
      MOP_X4:     wdata_o = f_times4(acc_y_i);
      MOP_X1P5:   wdata_o = f_times1p5(acc_y_i);
      MOP_LOAD:   wdata_o = f_load(reg_i);
      MOP_RNDSAT: begin
        wdata_o = rnd.value;
        clamp_o = rnd.clamped;
      end
      MOP_ADD:    wdata_o = acc_y_i + acc_z_i;
      MOP_SUB:    wdata_o = acc_y_i - acc_z_i;
      default:    wr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mac_readback.sv
`timescale 1ns/1ps
module mac_readback
  import frac_mac_pkg::*;
(
  input  mac_op_e           op_i,
  input  acc_t              acc_y_i,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              rf_we_o
);
  always_comb begin
    rf_data_o = '0;
    rf_we_o   = 1'b1;
    case (op_i)
      MOP_RD_LO:  rf_data_o = acc_y_i[DATA_W-1:0];
      MOP_RD_MID: rf_data_o = acc_y_i[FRAC_W-1:LOW_W];
      MOP_RD_HI:  rf_data_o = {{(DATA_W-GUARD_W){acc_y_i[ACC_W-1]}}, acc_y_i[ACC_W-1:FRAC_W]};
      default:    rf_we_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/frac_mac_unit.sv
`timescale 1ns/1ps
module frac_mac_unit
  import frac_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [SEL_W-1:0]  sel_x_i,
  input  logic [SEL_W-1:0]  sel_y_i,
  input  logic [SEL_W-1:0]  sel_z_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              rf_we_o,
  output logic              sat_o
);
  mac_op_e                    op_e;
  acc_t                       prod;
  acc_t                       acc_y;
  acc_t                       acc_z;
  acc_t                       wdata;
  logic                       wr_en;
  logic [NACC-1:0]            acc_we;
  logic [NACC-1:0][ACC_W-1:0] acc_q;

  assign op_e = mac_op_e'(op_i);

  // destination decode: selector values past the bank write nothing
  always_comb begin
    acc_we = '0;
    for (int i = 0; i < NACC; i++)
      if (wr_en && sel_x_i == SEL_W'(i)) acc_we[i] = 1'b1;
  end

  mac_multiplier u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  mac_acc_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (acc_we),
    .wdata_i (wdata),
    .sel_y_i (sel_y_i),
    .sel_z_i (sel_z_i),
    .acc_q_o (acc_q),
    .acc_y_o (acc_y),
    .acc_z_o (acc_z)
  );

  mac_alu u_alu (
    .op_i    (op_e),
    .acc_y_i (acc_y),
    .acc_z_i (acc_z),
    .prod_i  (prod),
    .reg_i   (reg_i),
    .wdata_o (wdata),
    .wr_en_o (wr_en),
    .clamp_o (sat_o)
  );

  mac_readback u_rb (
    .op_i      (op_e),
    .acc_y_i   (acc_y),
    .rf_data_o (rf_data_o),
    .rf_we_o   (rf_we_o)
  );
endmodule

// File: rtl/frac_mac_chk.sv
`timescale 1ns/1ps
module frac_mac_chk
  import frac_mac_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [OP_W-1:0]            op_i,
  input logic [SEL_W-1:0]           sel_x_i,
  input logic [DATA_W-1:0]          reg_i,
  input logic [NACC-1:0]            acc_we,
  input logic [NACC-1:0][ACC_W-1:0] acc_q,
  input logic [DATA_W-1:0]          rf_data_o
);
  logic [SEL_W-1:0] x_q;
  acc_t             acc_at_xq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= sel_x_i;
  end

  always_comb begin
    acc_at_xq = '0;
    for (int i = 0; i < NACC; i++)
      if (x_q == SEL_W'(i)) acc_at_xq = acc_q[i];
  end

  a_r11_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_we));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_i inside {[4'd1:4'd8]}) |=> $stable(acc_q));

  a_r10_x3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_x_i == 2'd3) |=> $stable(acc_q));

  a_r6_load_place: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd5 && sel_x_i != 2'd3) |=>
      acc_at_xq == {{GUARD_W{$past(reg_i[DATA_W-1])}}, $past(reg_i), {LOW_W{1'b0}}});

  a_r7_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6 && sel_x_i != 2'd3) |=>
      (acc_at_xq[LOW_W-1:0] == '0) &&
      ($signed({acc_at_xq[ACC_W-1], acc_at_xq}) <= SAT_HI) &&
      ($signed({acc_at_xq[ACC_W-1], acc_at_xq}) >= SAT_LO));

  a_r9_hi_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd11) |-> (rf_data_o[DATA_W-1:GUARD_W] == {(DATA_W-GUARD_W){rf_data_o[GUARD_W-1]}}));
endmodule

bind frac_mac_unit frac_mac_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_i      (op_i),
  .sel_x_i   (sel_x_i),
  .reg_i     (reg_i),
  .acc_we    (acc_we),
  .acc_q     (acc_q),
  .rf_data_o (rf_data_o)
);

// File: tb/frac_mac_unit_tb.sv
`timescale 1ns/1ps
module frac_mac_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] sx = '0, sy = '0, sz = '0;
  logic [7:0] a = '0, b = '0, r = '0;
  logic [7:0] rf_data;
  logic       rf_we, sat;

  int checks = 0;
  int fails  = 0;
  logic [21:0] m [3];

  always #10 clk = ~clk;

  frac_mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .sel_x_i(sx), .sel_y_i(sy), .sel_z_i(sz),
    .a_i(a), .b_i(b), .reg_i(r), .rf_data_o(rf_data), .rf_we_o(rf_we), .sat_o(sat)
  );

  function automatic int sx22(input logic [21:0] v);
    return int'($signed({{10{v[21]}}, v}));
  endfunction

  function automatic logic [21:0] src(input logic [1:0] s);
    return (s == 2'd3) ? 22'd0 : m[s];
  endfunction

  // bench model written with integer arithmetic
  function automatic logic [21:0] model(input logic [3:0] o, input logic [21:0] yv,
                                        input logic [21:0] zv, input logic [7:0] aa,
                                        input logic [7:0] bb, input logic [7:0] rr,
                                        output bit clamp);
    int p, y, t;
    p = int'($signed(aa)) * int'($signed(bb)) * 2;
    y = sx22(yv);
    clamp = 0;
    case (o)
      4'd1: return 22'(p);
      4'd2: return 22'(p + y);
      4'd3: return 22'(y * 4);
      4'd4: return 22'(y + (y >>> 1));
      4'd5: return 22'(int'($signed(rr)) * 256);
      4'd6: begin
        t = ((y + 128) >>> 8) * 256;
        if (t > 32512)  begin t = 32512;  clamp = 1; end
        if (t < -32768) begin t = -32768; clamp = 1; end
        return 22'(t);
      end
      4'd7: return 22'(y + sx22(zv));
      4'd8: return 22'(y - sx22(zv));
      default: return 22'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_acc(input logic [1:0] i, input string req);
    logic [7:0] lo, mid, hi;
    @(negedge clk);
    sy = i; op = 4'd9;  #1 lo  = rf_data; check({req, " R9 we"}, 32'(rf_we), 32'd1);
    op = 4'd10; #1 mid = rf_data;
    op = 4'd11; #1 hi  = rf_data;
    check({req, " R9 hi sign"}, 32'(hi[7:6]), 32'({2{hi[5]}}));
    op = 4'd0; #1 check({req, " R9 we idle"}, 32'(rf_we), 32'd0);
    check(req, 32'({hi[5:0], mid, lo}), 32'(m[i]));
  endtask

  task automatic issue(input logic [3:0] o, input logic [1:0] x, input logic [1:0] y,
                       input logic [1:0] z, input logic [7:0] aa, input logic [7:0] bb,
                       input logic [7:0] rr, input string req);
    logic [21:0] e;
    bit cl;
    e = model(o, src(y), src(z), aa, bb, rr, cl);
    @(negedge clk);
    op = o; sx = x; sy = y; sz = z; a = aa; b = bb; r = rr;
    #1;
    if (o == 4'd6) check({req, " R7 sat_o"}, 32'(sat), 32'(cl));
    @(negedge clk);
    op = 4'd0; sx = 2'd3;
    if (o >= 4'd1 && o <= 4'd8 && x != 2'd3) begin
      m[x] = e;
      read_acc(x, req);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) read_acc(2'(i), "R1 reset");
  endtask

  task automatic t_mul;
    issue(4'd1, 2'd0, 0, 0, 8'h40, 8'hC0, 0, "R2 half*-half");
    issue(4'd1, 2'd1, 0, 0, 8'h80, 8'h80, 0, "R2 -1*-1");
    issue(4'd1, 2'd2, 0, 0, 8'h7F, 8'h7F, 0, "R2 max*max");
    check("R2 -1*-1 value", 32'(m[1]), 32'h008000);
  endtask

  task automatic t_mac;
    issue(4'd2, 2'd2, 2'd1, 0, 8'h20, 8'h20, 0, "R3 mac");
    issue(4'd2, 2'd0, 2'd3, 0, 8'h80, 8'h7F, 0, "R3 mac zero src");
  endtask

  task automatic t_load_scale;
    issue(4'd5, 2'd0, 0, 0, 0, 0, 8'h81, "R6 load neg");
    issue(4'd5, 2'd1, 0, 0, 0, 0, 8'h7F, "R6 load pos");
    for (int k = 0; k < 4; k++) issue(4'd3, 2'd1, 2'd1, 0, 0, 0, 0, "R4 x4 wrap");
    issue(4'd4, 2'd2, 2'd0, 0, 0, 0, 0, "R5 x1.5 neg");
    issue(4'd4, 2'd2, 2'd2, 0, 0, 0, 0, "R5 x1.5 again");
    issue(4'd4, 2'd0, 2'd1, 0, 0, 0, 0, "R5 x1.5 wrapped");
  endtask

  task automatic t_round;
    issue(4'd5, 2'd0, 0, 0, 0, 0, 8'h40, "R6 load");
    issue(4'd2, 2'd0, 2'd0, 0, 8'h01, 8'h40, 0, "R3 small mac");
    issue(4'd6, 2'd1, 2'd0, 0, 0, 0, 0, "R7 round up");
    check("R7 round value", 32'(m[1]), 32'h004100);
    issue(4'd5, 2'd2, 0, 0, 0, 0, 8'h7F, "R6 load max");
    issue(4'd2, 2'd2, 2'd2, 0, 8'h01, 8'h40, 0, "R3 to boundary");
    issue(4'd6, 2'd0, 2'd2, 0, 0, 0, 0, "R7 boundary clamp");
    check("R7 boundary value", 32'(m[0]), 32'h007F00);
    issue(4'd5, 2'd1, 0, 0, 0, 0, 8'h80, "R6 load -1");
    issue(4'd3, 2'd1, 2'd1, 0, 0, 0, 0, "R4 x4 neg");
    issue(4'd6, 2'd2, 2'd1, 0, 0, 0, 0, "R7 neg clamp");
    issue(4'd6, 2'd2, 2'd0, 0, 0, 0, 0, "R7 in range");
  endtask

  task automatic t_addsub;
    issue(4'd7, 2'd0, 2'd1, 2'd2, 0, 0, 0, "R8 add");
    issue(4'd8, 2'd1, 2'd0, 2'd2, 0, 0, 0, "R8 sub");
    issue(4'd8, 2'd2, 2'd3, 2'd0, 0, 0, 0, "R8 negate");
    issue(4'd3, 2'd0, 2'd1, 0, 0, 0, 0, "R4 x4");
    issue(4'd7, 2'd0, 2'd0, 2'd0, 0, 0, 0, "R8 add wrap");
  endtask

  task automatic t_no_effect;
    issue(4'd1, 2'd3, 0, 0, 8'h7F, 8'h7F, 0, "R10 x3");
    issue(4'd5, 2'd3, 0, 0, 0, 0, 8'h55, "R10 x3 load");
    issue(4'd0, 2'd0, 0, 0, 8'h7F, 8'h7F, 8'h11, "R10 idle");
    issue(4'd12, 2'd1, 0, 0, 8'h7F, 8'h7F, 8'h11, "R10 op12");
    issue(4'd15, 2'd2, 0, 0, 8'h7F, 8'h7F, 8'h11, "R10 op15");
    for (int i = 0; i < 3; i++) read_acc(2'(i), "R10 R11 unchanged");
  endtask

  initial begin
    m[0] = '0; m[1] = '0; m[2] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_mul();
    t_mac();
    t_load_scale();
    t_round();
    t_addsub();
    t_no_effect();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule